// File: doc/BRIEF.md
# Event and Interval Profiling Counter

This block watches a vector of single-bit system event lines (interrupt requests, DMA triggers, comparator matches on processor activity) and measures them with no software involvement while it runs. In event mode it counts the cycles in which one chosen line is high. In interval mode it times the clock cycles from a chosen start line to a chosen stop line, and a second register keeps the longest interval seen across any number of start/stop rounds.

Software programs the mode, three line indices, a threshold and an enable, and can clear both counts at once. A one-cycle threshold pulse marks the moment the running count first reaches the programmed value, for example to flag a control loop that has overrun its time budget. The count saturates at all ones instead of wrapping.

Top module: `evt_span_profiler`

## Requirements
- R1: After reset, count_o, max_o, running_o and thr_evt_o are all 0.
- R2: In event mode (mode_i = 0) with en_i high, every clock edge at which line evt_i[cnt_sel_i] is high adds exactly one to count_o; other edges leave it unchanged.
- R3: In interval mode (mode_i = 1) with en_i high, an edge with line evt_i[start_sel_i] high sets count_o to 0 and running_o to 1, also when running_o is already 1 (restart).
- R4: While running_o is 1 and no start occurs, count_o rises by one per edge, the stop edge included, so after a start at edge t and a stop at edge t+k count_o holds k and running_o becomes 0; afterwards count_o stays frozen.
- R5: A stop line (evt_i[stop_sel_i]) high while running_o is 0 changes neither count_o nor max_o.
- R6: At a stop edge, max_o becomes the larger of its old value and the final interval; max_o never decreases except by clear or reset.
- R7: count_o saturates at all ones and never wraps to 0 by counting.
- R8: sw_clr_i high at an edge sets count_o, max_o and running_o to 0 and overrides any start, stop or count event in that cycle.
- R9: thr_evt_o is high for exactly one cycle, the first cycle in which count_o holds a value equal to thresh_i after holding a different value.
- R10: With en_i low and sw_clr_i low, count_o, max_o and running_o hold their values whatever the event lines do.
- R11: When the start and stop lines are both high at an edge in interval mode, the start wins: count_o becomes 0, running_o becomes 1, max_o is unchanged.
- R12: Only the line addressed by a select index has an effect; activity on the other lines changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Profiling enable |
| mode_i | input | 1 | 0 = event count, 1 = start/stop interval |
| sw_clr_i | input | 1 | Clear count, maximum and running state |
| evt_i | input | NUM_EVT | Event lines, one per source |
| cnt_sel_i | input | SEL_W | Index of the counted line |
| start_sel_i | input | SEL_W | Index of the start line |
| stop_sel_i | input | SEL_W | Index of the stop line |
| thresh_i | input | CNT_W | Threshold value for the pulse |
| count_o | output | CNT_W | Running or frozen count |
| max_o | output | CNT_W | Longest interval recorded |
| running_o | output | 1 | Interval measurement in progress |
| thr_evt_o | output | 1 | One-cycle threshold pulse |

## Verification
Properties evaluated every cycle cover the saturation hold, the zero count after a start, the single-cycle width of the threshold pulse, the monotonic maximum, the idle stop that leaves both counts alone, the freeze under a low enable and the idle state after a clear. Exact interval lengths, the restart and start-beats-stop orderings, line selection and the maximum comparison against an older, larger interval can only be shown by the bench's scripted sequences, which compare each count against values derived from the cycle numbering of the start and stop edges.

// File: rtl/prof_pkg.sv
package prof_pkg;

  typedef enum logic {
    MODE_EVENT = 1'b0,
    MODE_SPAN  = 1'b1
  } prof_mode_e;

  // Per-cycle commands from the sequencer to the datapaths
  typedef struct packed {
    logic clr;   // software clear: count and peak to zero
    logic zero;  // start of an interval: count to zero
    logic inc;   // add one to the count (saturating)
    logic upd;   // interval closes: offer new count to the peak register
  } prof_ctl_t;

endpackage

// File: rtl/prof_evt_mux.sv
module prof_evt_mux #(
  parameter int NUM_EVT = 16,
  parameter int SEL_W   = $clog2(NUM_EVT)
) (
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic [SEL_W-1:0]   sel_i,
  output logic               hit_o
);

  // Indices beyond the line count select nothing
  always_comb begin
    hit_o = 1'b0;
    for (int i = 0; i < NUM_EVT; i++) begin
      if (sel_i == SEL_W'(i)) hit_o = evt_i[i];
    end
  end

endmodule

// File: rtl/prof_seq.sv
module prof_seq
  import prof_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  prof_mode_e mode_i,
  input  logic       sw_clr_i,
  input  logic       cnt_hit_i,
  input  logic       start_hit_i,
  input  logic       stop_hit_i,
  output prof_ctl_t  ctl_o,
  output logic       running_o
);

  logic running_q, running_d;
  logic span_act;     // interval mode active this cycle
  logic start_take;   // start accepted (wins over stop)
  logic stop_take;    // stop accepted (only while running)

  assign span_act   = en_i && !sw_clr_i && (mode_i == MODE_SPAN);
  assign start_take = span_act && start_hit_i;
  assign stop_take  = span_act && running_q && stop_hit_i && !start_hit_i;

  always_comb begin
    ctl_o     = '0;
    ctl_o.clr = sw_clr_i;
    if (!sw_clr_i && en_i) begin
      if (mode_i == MODE_EVENT) begin
        ctl_o.inc = cnt_hit_i;
      end else if (start_hit_i) begin
        ctl_o.zero = 1'b1;
      end else if (running_q) begin
        ctl_o.inc = 1'b1;
        ctl_o.upd = stop_hit_i;
      end
    end
  end

  always_comb begin
    running_d = running_q;
    if (sw_clr_i)        running_d = 1'b0;
    else if (start_take) running_d = 1'b1;
    else if (stop_take)  running_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) running_q <= 1'b0;
    else         running_q <= running_d;
  end

  assign running_o = running_q;

  // R8: a clear leaves the block idle
  p_clr_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_clr_i |=> !running_q);

  // R3: an accepted start always leaves a measurement running
  p_start_runs_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_take |=> running_q);

endmodule

// File: rtl/prof_count.sv
module prof_count
  import prof_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  prof_ctl_t        ctl_i,
  input  logic [CNT_W-1:0] thresh_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] count_next_o,
  output logic             thr_o
);

  localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

  function automatic logic [CNT_W-1:0] sat_add1(input logic [CNT_W-1:0] v);
    return (v == CNT_TOP) ? v : v + CNT_W'(1);
  endfunction

  logic [CNT_W-1:0] count_q, count_d;
  logic             thr_q, thr_d;

  always_comb begin
    count_d = count_q;
    if (ctl_i.clr || ctl_i.zero) count_d = '0;
    else if (ctl_i.inc)          count_d = sat_add1(count_q);
  end

  // Pulse only on arrival at the threshold, not while resting on it
  assign thr_d = (count_d == thresh_i) && (count_d != count_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      thr_q   <= 1'b0;
    end else begin
      count_q <= count_d;
      thr_q   <= thr_d;
    end
  end

  assign count_o      = count_q;
  assign count_next_o = count_d;
  assign thr_o        = thr_q;

  // R7: at full scale, counting keeps the count at full scale
  p_no_overflow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_q == CNT_TOP && !ctl_i.clr && !ctl_i.zero) |=> (count_q == CNT_TOP));

  // R3: a start zeroes the count
  p_start_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_i.zero |=> (count_q == '0));

  // R9: the threshold pulse never lasts two cycles
  p_thr_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thr_q |=> !thr_q);

endmodule

// File: rtl/prof_peak.sv
module prof_peak #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             upd_i,
  input  logic [CNT_W-1:0] cand_i,
  output logic [CNT_W-1:0] max_o
);

  function automatic logic [CNT_W-1:0] larger(input logic [CNT_W-1:0] a,
                                              input logic [CNT_W-1:0] b);
    return (a > b) ? a : b;
  endfunction

  logic [CNT_W-1:0] max_q, max_d;

  always_comb begin
    max_d = max_q;
    if (clr_i)      max_d = '0;
    else if (upd_i) max_d = larger(max_q, cand_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) max_q <= '0;
    else         max_q <= max_d;
  end

  assign max_o = max_q;

  // R6: without a clear the recorded maximum never falls
  p_max_monotone_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (max_q >= $past(max_q)));

endmodule

// File: rtl/evt_span_profiler.sv
module evt_span_profiler
  import prof_pkg::*;
#(
  parameter int NUM_EVT = 16,
  parameter int CNT_W   = 16,
  parameter int SEL_W   = $clog2(NUM_EVT)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               mode_i,
  input  logic               sw_clr_i,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic [SEL_W-1:0]   cnt_sel_i,
  input  logic [SEL_W-1:0]   start_sel_i,
  input  logic [SEL_W-1:0]   stop_sel_i,
  input  logic [CNT_W-1:0]   thresh_i,
  output logic [CNT_W-1:0]   count_o,
  output logic [CNT_W-1:0]   max_o,
  output logic               running_o,
  output logic               thr_evt_o
);

  localparam int NUM_SEL = 3;  // counted, start, stop

  logic [NUM_SEL-1:0][SEL_W-1:0] sels;
  logic [NUM_SEL-1:0]            hits;
  logic                          cnt_hit, start_hit, stop_hit;
  prof_ctl_t                     ctl;
  logic [CNT_W-1:0]              count_next;

  assign sels = {stop_sel_i, start_sel_i, cnt_sel_i};

  for (genvar g = 0; g < NUM_SEL; g++) begin : g_sel
    prof_evt_mux #(.NUM_EVT(NUM_EVT), .SEL_W(SEL_W)) i_mux (
      .evt_i (evt_i),
      .sel_i (sels[g]),
      .hit_o (hits[g])
    );
  end

  assign cnt_hit   = hits[0];
  assign start_hit = hits[1];
  assign stop_hit  = hits[2];

  prof_seq i_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .mode_i      (prof_mode_e'(mode_i)),
    .sw_clr_i    (sw_clr_i),
    .cnt_hit_i   (cnt_hit),
    .start_hit_i (start_hit),
    .stop_hit_i  (stop_hit),
    .ctl_o       (ctl),
    .running_o   (running_o)
  );

  prof_count #(.CNT_W(CNT_W)) i_count (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ctl_i        (ctl),
    .thresh_i     (thresh_i),
    .count_o      (count_o),
    .count_next_o (count_next),
    .thr_o        (thr_evt_o)
  );

  prof_peak #(.CNT_W(CNT_W)) i_peak (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (ctl.clr),
    .upd_i  (ctl.upd),
    .cand_i (count_next),
    .max_o  (max_o)
  );

  // R5: a stop seen while idle touches neither count
  p_idle_stop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && mode_i && !sw_clr_i && !running_o && stop_hit && !start_hit)
      |=> ($stable(count_o) && $stable(max_o)));

  // R10: with the enable low, all state holds
  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !sw_clr_i)
      |=> ($stable(count_o) && $stable(max_o) && $stable(running_o)));

endmodule

// File: tb/test_evt_span_profiler.sv
module test_evt_span_profiler;

  localparam int NUM_EVT = 8;
  localparam int CNT_W   = 8;
  localparam int SEL_W   = 3;
  localparam int NVEC    = 31;

  // Vector: {clr, en, mode, evt[7:0], exp_cnt[7:0], exp_max[7:0], exp_thr}
  // Fixed selects: counted line 2, start line 0, stop line 1; threshold 3
  localparam logic [27:0] VEC [NVEC] = '{
    {1'b0,1'b1,1'b0,8'h04,8'd1,8'd0,1'b0},  // 0  R2
    {1'b0,1'b1,1'b0,8'h04,8'd2,8'd0,1'b0},  // 1  R2
    {1'b0,1'b1,1'b0,8'h00,8'd2,8'd0,1'b0},  // 2  R2
    {1'b0,1'b1,1'b0,8'h01,8'd2,8'd0,1'b0},  // 3  R12 unselected line
    {1'b0,1'b1,1'b0,8'h04,8'd3,8'd0,1'b1},  // 4  R9
    {1'b0,1'b1,1'b0,8'h04,8'd4,8'd0,1'b0},  // 5  R9 no repeat
    {1'b0,1'b0,1'b0,8'h04,8'd4,8'd0,1'b0},  // 6  R10
    {1'b1,1'b1,1'b0,8'h00,8'd0,8'd0,1'b0},  // 7  R8
    {1'b0,1'b1,1'b1,8'h02,8'd0,8'd0,1'b0},  // 8  R5 idle stop
    {1'b0,1'b1,1'b1,8'h01,8'd0,8'd0,1'b0},  // 9  R3 start
    {1'b0,1'b1,1'b1,8'h00,8'd1,8'd0,1'b0},  // 10 R4
    {1'b0,1'b1,1'b1,8'h00,8'd2,8'd0,1'b0},  // 11 R4
    {1'b0,1'b1,1'b1,8'h00,8'd3,8'd0,1'b1},  // 12 R9
    {1'b0,1'b1,1'b1,8'h02,8'd4,8'd4,1'b0},  // 13 R4 R6 stop
    {1'b0,1'b1,1'b1,8'h00,8'd4,8'd4,1'b0},  // 14 R4 frozen
    {1'b0,1'b1,1'b1,8'h01,8'd0,8'd4,1'b0},  // 15 R3
    {1'b0,1'b1,1'b1,8'h00,8'd1,8'd4,1'b0},  // 16
    {1'b0,1'b1,1'b1,8'h02,8'd2,8'd4,1'b0},  // 17 R6 shorter interval
    {1'b0,1'b1,1'b1,8'h01,8'd0,8'd4,1'b0},  // 18
    {1'b0,1'b1,1'b1,8'h00,8'd1,8'd4,1'b0},  // 19
    {1'b0,1'b1,1'b1,8'h01,8'd0,8'd4,1'b0},  // 20 R3 restart
    {1'b0,1'b1,1'b1,8'h00,8'd1,8'd4,1'b0},  // 21
    {1'b0,1'b1,1'b1,8'h00,8'd2,8'd4,1'b0},  // 22
    {1'b0,1'b1,1'b1,8'h00,8'd3,8'd4,1'b1},  // 23 R9
    {1'b0,1'b1,1'b1,8'h00,8'd4,8'd4,1'b0},  // 24
    {1'b0,1'b1,1'b1,8'h00,8'd5,8'd4,1'b0},  // 25
    {1'b0,1'b1,1'b1,8'h02,8'd6,8'd6,1'b0},  // 26 R6 longer interval
    {1'b0,1'b1,1'b1,8'h03,8'd0,8'd6,1'b0},  // 27 R11 idle
    {1'b0,1'b1,1'b1,8'h00,8'd1,8'd6,1'b0},  // 28
    {1'b0,1'b1,1'b1,8'h03,8'd0,8'd6,1'b0},  // 29 R11 running
    {1'b0,1'b1,1'b1,8'h02,8'd1,8'd6,1'b0}   // 30 R4
  };

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               en = 1'b0;
  logic               mode = 1'b0;
  logic               clr = 1'b0;
  logic [NUM_EVT-1:0] evt = '0;
  logic [SEL_W-1:0]   cnt_sel = 3'd2;
  logic [SEL_W-1:0]   start_sel = 3'd0;
  logic [SEL_W-1:0]   stop_sel = 3'd1;
  logic [CNT_W-1:0]   thresh = 8'd3;
  logic [CNT_W-1:0]   count, maxv;
  logic               running, thr;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  evt_span_profiler #(.NUM_EVT(NUM_EVT), .CNT_W(CNT_W), .SEL_W(SEL_W)) i_evt_span_profiler (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .en_i        (en),
    .mode_i      (mode),
    .sw_clr_i    (clr),
    .evt_i       (evt),
    .cnt_sel_i   (cnt_sel),
    .start_sel_i (start_sel),
    .stop_sel_i  (stop_sel),
    .thresh_i    (thresh),
    .count_o     (count),
    .max_o       (maxv),
    .running_o   (running),
    .thr_evt_o   (thr)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Drive at the falling edge, sample just after the next rising edge
  task automatic cyc(input logic c, input logic e, input logic m,
                     input logic [NUM_EVT-1:0] ev);
    @(negedge clk);
    clr = c; en = e; mode = m; evt = ev;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int pulses;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1", "count", 32'(count), 0);
    chk("R1", "max", 32'(maxv), 0);
    chk("R1", "running", 32'(running), 0);
    chk("R1", "thr", 32'(thr), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // Table walk
    for (int i = 0; i < NVEC; i++) begin
      logic [27:0] v;
      string tag;
      v = VEC[i];
      tag = $sformatf("vec%0d", i);
      cyc(v[27], v[26], v[25], v[24:17]);
      chk("R2-R12 table", {tag, " count"}, 32'(count), 32'(v[16:9]));
      chk("R6 table",     {tag, " max"},   32'(maxv),  32'(v[8:1]));
      chk("R9 table",     {tag, " thr"},   32'(thr),   32'(v[0]));
    end

    // R7 saturation: start and run far beyond full scale
    cyc(1'b1, 1'b1, 1'b1, 8'h00);
    @(negedge clk);
    thresh = 8'd255;
    cyc(1'b0, 1'b1, 1'b1, 8'h01);
    chk("R3", "count after start", 32'(count), 0);
    chk("R3", "running after start", 32'(running), 1);
    pulses = 0;
    for (int k = 0; k < 300; k++) begin
      cyc(1'b0, 1'b1, 1'b1, 8'h00);
      if (thr) pulses++;
    end
    chk("R7", "saturated count", 32'(count), 255);
    chk("R9", "pulses at full scale", 32'(pulses), 1);
    cyc(1'b0, 1'b1, 1'b1, 8'h02);
    chk("R7", "count after stop", 32'(count), 255);
    chk("R6", "max after stop", 32'(maxv), 255);
    chk("R4", "running after stop", 32'(running), 0);

    // R10 enable low with a start line active
    cyc(1'b0, 1'b0, 1'b1, 8'h01);
    chk("R10", "count held", 32'(count), 255);
    chk("R10", "running held", 32'(running), 0);

    // R8 clear beats a simultaneous start
    cyc(1'b1, 1'b1, 1'b1, 8'h01);
    chk("R8", "count cleared", 32'(count), 0);
    chk("R8", "max cleared", 32'(maxv), 0);
    chk("R8", "running cleared", 32'(running), 0);
    cyc(1'b0, 1'b1, 1'b1, 8'h00);
    chk("R8", "count stays idle", 32'(count), 0);

    // R12 reselect counted line to 5 in event mode
    @(negedge clk);
    cnt_sel = 3'd5;
    cyc(1'b0, 1'b1, 1'b0, 8'h04);
    chk("R12", "old line ignored", 32'(count), 0);
    cyc(1'b0, 1'b1, 1'b0, 8'h20);
    chk("R12", "new line counted", 32'(count), 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule